// File: doc/BRIEF.md
# Double-Rate Serial-to-Parallel Converter with Word-Boundary Slip

This block turns a serial bit stream into 4-bit words. Two input registers sample the serial line, one on each edge of a fast bit clock. Every rising bit-clock edge moves the sampled pair into a short history. A divided clock runs at half the bit-clock rate and is phase-aligned with it, so four new bits arrive in each divided cycle. On each divided edge a 4-bit window is taken from the history and registered on the output.

Where the window sits in the stream is set by a slip offset. Alignment logic in the fabric pulses `bitslip` while it searches for a training pattern. Each accepted request moves the window. The moves alternate between one bit toward older data and three bits toward newer data. A move that would reach past the newest captured bit wraps around by one whole word.

Top module: `ddr_deser_slip`

## Requirements
- R1: The bit sampled on a rising bit-clock edge comes earlier in the stream than the bit sampled on the following falling edge. Output bit `q[0]` (Q1) holds the earliest bit of a word and `q[3]` (Q4) holds the latest.
- R2: With slip offset 0, each divided edge loads `q` with four consecutive stream bits. Q4 is the bit sampled three bit-clock edges (of either polarity) before that divided edge, and Q1 is the bit sampled six edges before it. Consecutive words join without a gap.
- R3: The 1st, 3rd, 5th and every other odd-numbered accepted request moves the window one bit older. Each Q then takes the bit sampled one edge earlier than before.
- R4: Every even-numbered accepted request moves the window three bits newer, wrapping one word older when needed. The net result is that the offset equals the number of accepted requests modulo 4, and Qi takes the bit sampled 7-i+offset edges before the loading divided edge.
- R5: Take a request sampled high at divided edge E. The word loaded at E still uses the old boundary, and the word loaded at E+1 uses the new one. Logic that samples `q` on the divided clock therefore sees the realigned word at E+2.
- R6: A request is a rising edge of `bitslip` as seen at divided edges. Holding `bitslip` high for several edges counts as one request. A second request needs `bitslip` low at one or more divided edges in between.
- R7: A synchronous reset, sampled by the divided clock, clears `q`, the slip offset and the alternation state. While reset is held, the bit-clock input and history registers are cleared as well. The word loaded at the first divided edge after release is therefore all zeros, and the next request is a move one bit older.
- R8: Requests made while reset is asserted are ignored. After release, words use offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock; serial data is sampled on both of its edges |
| clk_div | input | 1 | Divided word clock at half the bit-clock rate, with its rising edges aligned to rising bit-clock edges |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data input |
| bitslip | input | 1 | Boundary-move request, sampled on `clk_div` |
| q | output | 4 | Parallel word; `q[0]` is the earliest bit (Q1) and `q[3]` the latest (Q4) |

## Verification
The block has no parameters, so the bench builds its only configuration: a 4-bit word with a 2:1 clock ratio. A pseudo-random stream lets every window position be compared bit by bit against an edge-indexed model of the line. A table of requests takes the offset through all four values, across the wrap from 3 back to 0, and through held requests. Directed sequences force the line high to show the cleared input registers after reset. They also pulse requests during reset, make single moves, and hold the request for a long run.

// File: rtl/ddr_deser_slip.sv
`timescale 1ns/1ps
module ddr_deser_slip (
  input  logic       clk_bit,
  input  logic       clk_div,
  input  logic       rst,
  input  logic       din,
  input  logic       bitslip,
  output logic [3:0] q
);
  localparam int WORD_W = 4;
  localparam int HIST_W = 2 * WORD_W - 1;
  localparam int OFS_W  = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(HIST_W);

  logic              rise_bit;
  logic              fall_bit;
  logic [HIST_W-1:0] hist;
  logic              slip_prev;
  logic              left_next;
  logic [OFS_W-1:0]  slip_ofs;
  logic [OFS_W-1:0]  next_ofs;
  logic              take_slip;
  logic [WORD_W-1:0] window;

  always_ff @(posedge clk_bit)
    if (rst) rise_bit <= 1'b0;
    else     rise_bit <= din;

  always_ff @(negedge clk_bit)
    if (rst) fall_bit <= 1'b0;
    else     fall_bit <= din;

  always_ff @(posedge clk_bit)
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_W-3:0], rise_bit, fall_bit};

  assign take_slip = bitslip & ~slip_prev;
  assign next_ofs  = left_next ? slip_ofs - OFS_W'(WORD_W - 1)
                               : slip_ofs + OFS_W'(1);

  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      logic [IDX_W-1:0] idx;
      idx = IDX_W'(slip_ofs) + IDX_W'(WORD_W - 1 - i);
      window[i] = hist[idx];
    end
  end

  always_ff @(posedge clk_div) begin
    slip_prev <= bitslip;
    if (rst) begin
      q         <= '0;
      slip_ofs  <= '0;
      left_next <= 1'b0;
    end else begin
      q <= window;
      if (take_slip) begin
        slip_ofs  <= next_ofs;
        left_next <= ~left_next;
      end
    end
  end
endmodule

// File: rtl/ddr_deser_slip_chk.sv
`timescale 1ns/1ps
module ddr_deser_slip_chk (
  input logic       clk_div,
  input logic       rst,
  input logic       bitslip,
  input logic [3:0] q,
  input logic [1:0] slip_ofs,
  input logic       left_next
);
  // R7
  reset_clear_chk: assert property (@(posedge clk_div)
    rst |=> (q == 4'd0 && slip_ofs == 2'd0 && !left_next));

  // R6
  held_once_chk: assert property (@(posedge clk_div) disable iff (rst)
    (bitslip && $past(bitslip)) |=> $stable(slip_ofs));

  // R6
  idle_stable_chk: assert property (@(posedge clk_div) disable iff (rst)
    !bitslip |=> ($stable(slip_ofs) && $stable(left_next)));

  // R4
  net_step_chk: assert property (@(posedge clk_div) disable iff (rst)
    (bitslip && !$past(bitslip)) |=> slip_ofs == $past(slip_ofs) + 2'd1);

  // R3
  alternate_chk: assert property (@(posedge clk_div) disable iff (rst)
    (bitslip && !$past(bitslip)) |=> left_next != $past(left_next));
endmodule

bind ddr_deser_slip ddr_deser_slip_chk u_chk (
  .clk_div  (clk_div),
  .rst      (rst),
  .bitslip  (bitslip),
  .q        (q),
  .slip_ofs (slip_ofs),
  .left_next(left_next)
);

// File: tb/ddr_deser_slip_test.sv
`timescale 1ns/1ps
module ddr_deser_slip_test;
  logic       clk_bit = 1'b0;
  logic       clk_div = 1'b0;
  logic       rst     = 1'b1;
  logic       din     = 1'b0;
  logic       bitslip = 1'b0;
  logic [3:0] q;

  int vectors     = 0;
  int miscompares = 0;
  bit done        = 1'b0;
  bit force_one   = 1'b0;
  bit stream [1024];
  int drv_idx     = 0;
  int e_now       = 0;

  // {bitslip, offset used by the word loaded at that edge}
  localparam logic [2:0] VEC [20] = '{
    3'b000, 3'b000, 3'b100, 3'b001, 3'b001,
    3'b101, 3'b110, 3'b110, 3'b010, 3'b110,
    3'b011, 3'b111, 3'b000, 3'b000, 3'b100,
    3'b101, 3'b001, 3'b101, 3'b010, 3'b010
  };

  ddr_deser_slip uut (
    .clk_bit(clk_bit),
    .clk_div(clk_div),
    .rst    (rst),
    .din    (din),
    .bitslip(bitslip),
    .q      (q)
  );

  always #2.5 clk_bit = ~clk_bit;

  initial begin
    #2.5;
    clk_div = 1'b1;
    forever #5 clk_div = ~clk_div;
  end

  initial begin : driver
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < 1024; i++) begin
      stream[i] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    din = stream[0];
    forever begin
      @(clk_bit);
      #1.25;
      drv_idx++;
      din = force_one ? 1'b1 : stream[drv_idx & 1023];
    end
  end

  function automatic bit sbit(int n);
    return (n < 0) ? 1'b0 : stream[n & 1023];
  endfunction

  function automatic logic [3:0] model_q(int e, int s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = sbit(e - 6 - s + i);
    return r;
  endfunction

  task automatic step();
    @(posedge clk_div);
    #3;
    e_now = drv_idx - 1;
  endtask

  task automatic check(string tag, logic [3:0] exp);
    vectors++;
    if (q !== exp) begin
      miscompares++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    rst = 1'b1;
    bitslip = 1'b0;
    repeat (3) step();
    check("R7 output zero in reset", 4'h0);
    rst = 1'b0;
    repeat (4) step();

    for (int i = 0; i < 20; i++) begin
      bitslip = VEC[i][2];
      step();
      check($sformatf("R1 R2 R3 R4 R5 R6 table row %0d", i),
            model_q(e_now, int'(VEC[i][1:0])));
    end

    bitslip = 1'b0;
    step();
    rst = 1'b1;
    force_one = 1'b1;
    bitslip = 1'b1;
    step();
    bitslip = 1'b0;
    step();
    bitslip = 1'b1;
    step();
    check("R7 output cleared during reset", 4'h0);
    bitslip = 1'b0;
    step();
    rst = 1'b0;
    step();
    check("R7 input registers cleared", 4'h0);
    step();
    step();
    check("R7 history refills with ones", 4'hF);
    force_one = 1'b0;
    repeat (3) step();
    check("R8 offset zero after reset-time requests", model_q(e_now, 0));

    bitslip = 1'b1;
    step();
    check("R5 old boundary on request edge", model_q(e_now, 0));
    bitslip = 1'b0;
    step();
    check("R3 first move one bit older", model_q(e_now, 1));

    bitslip = 1'b1;
    for (int j = 0; j < 5; j++) begin
      step();
      check($sformatf("R6 long hold cycle %0d", j), model_q(e_now, (j == 0) ? 1 : 2));
    end
    bitslip = 1'b0;
    step();
    check("R4 second move after long hold", model_q(e_now, 2));

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run incomplete, expected completion");
      summary();
      $finish;
    end
  end
endmodule